// File: doc/BRIEF.md
# Multi-Mode Sample Readout Sequencer

This block is the host-side read path of a six-channel sampling front end. A host reads results over a 16-bit bus using an active-low read strobe. The strobe is sampled synchronously. Each rising edge of the strobe ends one bus transfer. A 3-bit mode code picks the source of the data. Codes 0 to 5 address one channel directly. Code 6 steps round-robin through all channels. Code 7 drains an external result FIFO, which returns results in conversion order. The block then shapes each result into one, two or three transfers. The shape depends on two settings: byte mode, and whether a channel tag is prepended.

An 8-bit control write either loads the configuration or issues one-cycle commands. The commands are a reset of the read path and start requests for the three channel pairs. The parameter `CFG_FROM_WRITE` selects where the mode code and the tag option come from. When it is 1, they come from the register that the control write loads. When it is 0, they come straight from input pins. Byte mode always comes from a pin. Channels are numbered 0 to 5 in the order A0, A1, B0, B1, C0, C1.

Top module: `readout_seq`

## Requirements
- R1: After rst_ni is released, these all hold: hold_o = 0, reset_o = 0, fifo_pop_o = 0, the sequence position is the first transfer, the cycle pointer is channel 0, and the written configuration is mode 000 with tagging off.
- R2: Mode codes 0 to 5 return the 16-bit sample of that channel in a single transfer when byte_i = 0. The tag option has no effect in these modes.
- R3: With byte_i = 1 and no tag, a result takes two transfers. The first carries bits 7..0 and the second carries bits 15..8, each copied onto both halves of dout_o.
- R4: Mode 6 serves channels 0,1,2,3,4,5 and then returns to 0. The pointer moves only on the rising strobe edge that ends the last transfer of a result.
- R5: Tagging (tag option = 1, mode 6 or 7) with byte_i = 0 gives two transfers. The first is 16'h8000 | dv<<3 | ch. The second is the 16-bit sample.
- R6: Tagging with byte_i = 1 gives three transfers. The first is the byte {dv, ch[2:0], sample[3:0]}, the second is sample[7:0] and the third is sample[15:8], each copied onto both bus halves.
- R7: Mode 7 takes its data from fifo_data_i and its tag from fifo_ch_i, with dv = !fifo_empty_i. fifo_pop_o pulses together with the rising strobe that ends a result, and only when fifo_empty_i = 0.
- R8: With CFG_FROM_WRITE = 1, a control write with bit 7 = 1 loads the tag option from bit 3 and the mode from bits 2..0. A write with bit 7 = 0 leaves the configuration unchanged.
- R9: A control write with bit 7 = 0 makes hold_o equal {bit2, bit1, bit0} (pairs A, B, C) for exactly the next cycle.
- R10: A control write with bit 7 = 0 and bit 3 = 1 pulses reset_o in the next cycle. It also returns the sequence position to the first transfer and the cycle pointer to channel 0.
- R11: A change of the effective mode code returns the sequence position to the first transfer.
- R12: Each rising edge of rd_ni moves to the next transfer. The effective mode code must stay stable while rd_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_ni | input | 1 | Read strobe, active low |
| mode_i | input | 3 | Mode code pins (used when CFG_FROM_WRITE = 0) |
| add_i | input | 1 | Tag option pin (used when CFG_FROM_WRITE = 0) |
| byte_i | input | 1 | Byte-wide transfers when high |
| ctrl_we_i | input | 1 | Control write strobe, one cycle |
| ctrl_data_i | input | 8 | Control write byte |
| smp_data_i | input | 96 | Latest sample per channel, channel 0 in the low 16 bits |
| smp_valid_i | input | 6 | Per-channel data-valid flags |
| fifo_data_i | input | 16 | Head sample of the result FIFO |
| fifo_ch_i | input | 3 | Channel of the FIFO head |
| fifo_empty_i | input | 1 | FIFO holds no result |
| fifo_pop_o | output | 1 | Remove the FIFO head |
| dout_o | output | 16 | Read data bus |
| hold_o | output | 3 | Start pulses for pairs A, B, C (bit 2 = A) |
| reset_o | output | 1 | Reset command pulse |

## Verification
The bench builds two copies with the default NCH = 6 and DW = 16. One copy has CFG_FROM_WRITE = 0 and the other has CFG_FROM_WRITE = 1, and both receive the same strobe and data stimulus. Both configuration paths are therefore checked against one model, including the case where a mode change lands after a different number of register stages in each copy. The default widths make the full header layout reachable, as well as the packed tag byte with its four data bits and the six-way wrap of the cycle pointer.

// File: rtl/readout_pkg.sv
package readout_pkg;
  typedef enum logic [1:0] {SRC_DIRECT, SRC_CYCLE, SRC_FIFO} src_e;

  localparam logic [2:0] MODE_CYCLE = 3'd6;
  localparam logic [2:0] MODE_FIFO  = 3'd7;

  function automatic src_e mode_src(input logic [2:0] m);
    if (m == MODE_FIFO)       return SRC_FIFO;
    else if (m == MODE_CYCLE) return SRC_CYCLE;
    else                      return SRC_DIRECT;
  endfunction

  // index of last transfer in one result
  function automatic logic [1:0] last_step(input logic tag, input logic byte_w);
    if (tag && byte_w)      return 2'd2;
    else if (tag || byte_w) return 2'd1;
    else                    return 2'd0;
  endfunction
endpackage

// File: rtl/rs_ctrl_decode.sv
module rs_ctrl_decode #(
  parameter bit CFG_FROM_WRITE = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] data_i,
  input  logic [2:0] mode_pin_i,
  input  logic       add_pin_i,
  output logic [2:0] mode_o,
  output logic       add_o,
  output logic [2:0] hold_o,
  output logic       reset_o,
  output logic       rst_cmd_o
);
  logic cmd_wr, cfg_wr;
  logic unused_rsvd;

  assign cmd_wr      = we_i & ~data_i[7];
  assign cfg_wr      = we_i &  data_i[7];
  assign rst_cmd_o   = cmd_wr & data_i[3];
  assign unused_rsvd = ^data_i[6:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o  <= '0;
      reset_o <= 1'b0;
    end else begin
      hold_o  <= cmd_wr ? data_i[2:0] : 3'b000;
      reset_o <= rst_cmd_o;
    end
  end

  generate
    if (CFG_FROM_WRITE) begin : g_soft
      logic [2:0] mode_q;
      logic       add_q;
      logic       unused_pins;
      assign unused_pins = ^{mode_pin_i, add_pin_i};
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          mode_q <= 3'd0;
          add_q  <= 1'b0;
        end else if (cfg_wr) begin
          mode_q <= data_i[2:0];
          add_q  <= data_i[3];
        end
      end
      assign mode_o = mode_q;
      assign add_o  = add_q;
    end else begin : g_pin
      logic unused_cfg;
      assign unused_cfg = cfg_wr;
      assign mode_o = mode_pin_i;
      assign add_o  = add_pin_i;
    end
  endgenerate
endmodule

// File: rtl/rs_strobe_track.sv
module rs_strobe_track (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_ni,
  input  logic [1:0] last_i,
  input  logic       restart_i,
  output logic [1:0] step_o,
  output logic       done_o
);
  logic rd_q, rise, at_last;

  assign rise    = rd_ni & ~rd_q;
  assign at_last = (step_o >= last_i);
  assign done_o  = rise & at_last & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b1;
      step_o <= 2'd0;
    end else begin
      rd_q <= rd_ni;
      if (restart_i)    step_o <= 2'd0;
      else if (rise)    step_o <= at_last ? 2'd0 : step_o + 2'd1;
    end
  end
endmodule

// File: rtl/rs_chan_sel.sv
module rs_chan_sel
  import readout_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  src_e              src_i,
  input  logic [2:0]        mode_i,
  input  logic              advance_i,
  input  logic              clear_i,
  input  logic [NCH*DW-1:0] smp_data_i,
  input  logic [NCH-1:0]    smp_valid_i,
  input  logic [DW-1:0]     fifo_data_i,
  input  logic [CW-1:0]     fifo_ch_i,
  input  logic              fifo_empty_i,
  output logic [CW-1:0]     ptr_o,
  output logic [CW-1:0]     ch_o,
  output logic [DW-1:0]     data_o,
  output logic              dv_o
);
  logic [CW-1:0] dir_ch;
  logic [DW-1:0] ch_data [NCH];

  assign dir_ch = CW'(mode_i);

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign ch_data[g] = smp_data_i[g*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              ptr_o <= '0;
    else if (clear_i)                         ptr_o <= '0;
    else if (advance_i && src_i == SRC_CYCLE)
      ptr_o <= (ptr_o == CW'(NCH - 1)) ? '0 : ptr_o + 1'b1;
  end

  always_comb begin
    ch_o   = '0;
    data_o = '0;
    dv_o   = 1'b0;
    unique case (src_i)
      SRC_FIFO: begin
        ch_o   = fifo_ch_i;
        data_o = fifo_data_i;
        dv_o   = ~fifo_empty_i;
      end
      SRC_CYCLE: begin
        ch_o = ptr_o;
        for (int i = 0; i < NCH; i++) begin
          if (ptr_o == CW'(i)) begin
            data_o = ch_data[i];
            dv_o   = smp_valid_i[i];
          end
        end
      end
      default: begin
        ch_o = dir_ch;
        for (int i = 0; i < NCH; i++) begin
          if (dir_ch == CW'(i)) begin
            data_o = ch_data[i];
            dv_o   = smp_valid_i[i];
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/rs_word_fmt.sv
module rs_word_fmt #(
  parameter int DW = 16,
  parameter int CW = 3,
  localparam int BW = DW / 2
) (
  input  logic          tag_i,
  input  logic          byte_i,
  input  logic [1:0]    step_i,
  input  logic [CW-1:0] ch_i,
  input  logic [DW-1:0] data_i,
  input  logic          dv_i,
  output logic [DW-1:0] word_o
);
  logic [DW-1:0] header;
  logic [BW-1:0] tag_byte, lo_b, hi_b;

  assign header   = {1'b1, {(DW-2-CW){1'b0}}, dv_i, ch_i};
  assign tag_byte = {dv_i, ch_i, data_i[BW-CW-2:0]};
  assign lo_b     = data_i[BW-1:0];
  assign hi_b     = data_i[DW-1:BW];

  always_comb begin
    word_o = data_i;
    unique case ({tag_i, byte_i})
      2'b01: word_o = (step_i == 2'd0) ? {lo_b, lo_b} : {hi_b, hi_b};
      2'b10: word_o = (step_i == 2'd0) ? header : data_i;
      2'b11: begin
        if (step_i == 2'd0)      word_o = {tag_byte, tag_byte};
        else if (step_i == 2'd1) word_o = {lo_b, lo_b};
        else                     word_o = {hi_b, hi_b};
      end
      default: word_o = data_i;
    endcase
  end
endmodule

// File: rtl/readout_seq.sv
module readout_seq
  import readout_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 16,
  parameter bit CFG_FROM_WRITE = 1'b0,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_ni,
  input  logic [2:0]        mode_i,
  input  logic              add_i,
  input  logic              byte_i,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_data_i,
  input  logic [NCH*DW-1:0] smp_data_i,
  input  logic [NCH-1:0]    smp_valid_i,
  input  logic [DW-1:0]     fifo_data_i,
  input  logic [CW-1:0]     fifo_ch_i,
  input  logic              fifo_empty_i,
  output logic              fifo_pop_o,
  output logic [DW-1:0]     dout_o,
  output logic [2:0]        hold_o,
  output logic              reset_o
);
  logic [2:0]    eff_mode, mode_q;
  logic          eff_add, tag_on, rst_cmd, restart, seq_done;
  logic [1:0]    step, last;
  src_e          src;
  logic [CW-1:0] ptr, sel_ch;
  logic [DW-1:0] sel_data;
  logic          sel_dv;

  rs_ctrl_decode #(.CFG_FROM_WRITE(CFG_FROM_WRITE)) u_ctrl (
    .clk_i, .rst_ni,
    .we_i(ctrl_we_i), .data_i(ctrl_data_i),
    .mode_pin_i(mode_i), .add_pin_i(add_i),
    .mode_o(eff_mode), .add_o(eff_add),
    .hold_o, .reset_o, .rst_cmd_o(rst_cmd)
  );

  assign src     = mode_src(eff_mode);
  assign tag_on  = eff_add & (src != SRC_DIRECT);
  assign last    = last_step(tag_on, byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 3'd0;
    else         mode_q <= eff_mode;
  end

  assign restart = rst_cmd | (mode_q != eff_mode);

  rs_strobe_track u_strobe (
    .clk_i, .rst_ni, .rd_ni,
    .last_i(last), .restart_i(restart),
    .step_o(step), .done_o(seq_done)
  );

  rs_chan_sel #(.NCH(NCH), .DW(DW)) u_sel (
    .clk_i, .rst_ni,
    .src_i(src), .mode_i(eff_mode),
    .advance_i(seq_done), .clear_i(rst_cmd),
    .smp_data_i, .smp_valid_i,
    .fifo_data_i, .fifo_ch_i, .fifo_empty_i,
    .ptr_o(ptr), .ch_o(sel_ch), .data_o(sel_data), .dv_o(sel_dv)
  );

  rs_word_fmt #(.DW(DW), .CW(CW)) u_fmt (
    .tag_i(tag_on), .byte_i,
    .step_i(step), .ch_i(sel_ch), .data_i(sel_data), .dv_i(sel_dv),
    .word_o(dout_o)
  );

  assign fifo_pop_o = seq_done & (src == SRC_FIFO) & ~fifo_empty_i;
endmodule

// File: rtl/readout_seq_chk.sv
module readout_seq_chk #(
  parameter int NCH = 6,
  parameter int DW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_ni,
  input logic              byte_i,
  input logic              ctrl_we_i,
  input logic [7:0]        ctrl_data_i,
  input logic [NCH*DW-1:0] smp_data_i,
  input logic              fifo_empty_i,
  input logic              fifo_pop_o,
  input logic [DW-1:0]     dout_o,
  input logic [2:0]        hold_o,
  input logic              reset_o,
  input logic [2:0]        eff_mode,
  input logic [1:0]        step,
  input logic [CW-1:0]     ptr,
  input logic              seq_done,
  input logic              rst_cmd
);
  AST_DIRECT_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_ni && eff_mode < 3'(NCH) && !byte_i) |-> dout_o == smp_data_i[eff_mode*DW +: DW]); // R2
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr < CW'(NCH)); // R4
  AST_PTR_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ptr) |-> $past(seq_done || rst_cmd)); // R4
  AST_POP_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (rd_ni && !fifo_empty_i && eff_mode == 3'd7)); // R7
  AST_HOLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !ctrl_data_i[7]) |=> hold_o == $past(ctrl_data_i[2:0])); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_we_i && !ctrl_data_i[7]) |=> hold_o == 3'b000); // R9
  AST_RESET_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !ctrl_data_i[7] && ctrl_data_i[3]) |=> (reset_o && step == 2'd0 && ptr == '0)); // R10
  AST_MODE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(eff_mode) |=> step == 2'd0); // R11
  AST_MODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_ni && !$past(rd_ni)) |-> $stable(eff_mode)); // R12
endmodule

bind readout_seq readout_seq_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_ni(rd_ni), .byte_i(byte_i),
  .ctrl_we_i(ctrl_we_i), .ctrl_data_i(ctrl_data_i), .smp_data_i(smp_data_i),
  .fifo_empty_i(fifo_empty_i), .fifo_pop_o(fifo_pop_o), .dout_o(dout_o),
  .hold_o(hold_o), .reset_o(reset_o), .eff_mode(eff_mode), .step(step),
  .ptr(ptr), .seq_done(seq_done), .rst_cmd(rst_cmd)
);

// File: tb/readout_seq_bench.sv
module readout_seq_bench;
  localparam int NCH = 6;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_ni = 1'b1;
  logic [2:0] mode_pin = 3'd0;
  logic add_pin = 1'b0;
  logic byte_w = 1'b0;
  logic we = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [NCH*DW-1:0] smp = '0;
  logic [NCH-1:0] vld = '0;
  logic [DW-1:0] fdat = '0;
  logic [2:0] fch = 3'd0;
  logic fempty = 1'b1;

  logic pop_p, pop_s, rst_p, rst_s;
  logic [DW-1:0] dout_p, dout_s;
  logic [2:0] hold_p, hold_s;

  int checks = 0;
  int fails = 0;
  logic [2:0] m_mode = 3'd0;
  logic m_add = 1'b0;
  int m_step = 0;
  int m_ptr = 0;

  always #10 clk = ~clk;

  readout_seq #(.NCH(NCH), .DW(DW), .CFG_FROM_WRITE(1'b0)) u_readout_seq (
    .clk_i(clk), .rst_ni(rst_ni), .rd_ni(rd_ni), .mode_i(mode_pin), .add_i(add_pin),
    .byte_i(byte_w), .ctrl_we_i(we), .ctrl_data_i(wdata), .smp_data_i(smp),
    .smp_valid_i(vld), .fifo_data_i(fdat), .fifo_ch_i(fch), .fifo_empty_i(fempty),
    .fifo_pop_o(pop_p), .dout_o(dout_p), .hold_o(hold_p), .reset_o(rst_p));

  readout_seq #(.NCH(NCH), .DW(DW), .CFG_FROM_WRITE(1'b1)) u_readout_seq_soft (
    .clk_i(clk), .rst_ni(rst_ni), .rd_ni(rd_ni), .mode_i(3'd0), .add_i(1'b0),
    .byte_i(byte_w), .ctrl_we_i(we), .ctrl_data_i(wdata), .smp_data_i(smp),
    .smp_valid_i(vld), .fifo_data_i(fdat), .fifo_ch_i(fch), .fifo_empty_i(fempty),
    .fifo_pop_o(pop_s), .dout_o(dout_s), .hold_o(hold_s), .reset_o(rst_s));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int n_steps(input logic [2:0] md, input logic ad, input logic by);
    bit tag;
    tag = ad && md >= 3'd6;
    if (tag && by) return 3;
    if (tag || by) return 2;
    return 1;
  endfunction

  function automatic logic [15:0] exp_word(input logic [2:0] md, input logic ad, input logic by,
                                           input int st, input logic [2:0] ch,
                                           input logic [15:0] d, input logic dv);
    bit tag;
    logic [7:0] b;
    tag = ad && md >= 3'd6;
    if (!tag && !by) return d;
    if (!tag) return (st == 0) ? {d[7:0], d[7:0]} : {d[15:8], d[15:8]};
    if (!by) return (st == 0) ? {12'h800, dv, ch} : d;
    b = {dv, ch, d[3:0]};
    if (st == 0) return {b, b};
    if (st == 1) return {d[7:0], d[7:0]};
    return {d[15:8], d[15:8]};
  endfunction

  function automatic string req_of(input logic [2:0] md, input logic ad, input logic by);
    string s;
    s = (md < 3'd6) ? "R2" : (md == 3'd6) ? "R4" : "R7";
    if (ad && md >= 3'd6) s = {s, by ? "/R6" : "/R5"};
    else if (by)          s = {s, "/R3"};
    return {s, "/R12"};
  endfunction

  task automatic set_cfg(input logic [2:0] md, input logic ad);
    @(negedge clk);
    mode_pin = md;
    add_pin  = ad;
    we = 1'b1;
    wdata = {1'b1, 3'b000, ad, md};
    @(negedge clk);
    we = 1'b0;
    if (md != m_mode) m_step = 0;
    m_mode = md;
    m_add  = ad;
    repeat (2) @(negedge clk);
  endtask

  task automatic cmd(input logic rs, input logic [2:0] h);
    @(negedge clk);
    we = 1'b1;
    wdata = {1'b0, 3'b000, rs, h};
    @(negedge clk);
    we = 1'b0;
    chk(hold_p == h && hold_s == h, "R9 hold pulse", {hold_p, hold_s}, {h, h});
    chk(rst_p == rs && rst_s == rs, "R10 reset pulse", {rst_p, rst_s}, {rs, rs});
    if (rs) begin
      m_step = 0;
      m_ptr = 0;
    end
    @(negedge clk);
    chk(hold_p == 3'b0 && hold_s == 3'b0 && !rst_p && !rst_s, "R9 pulse ends",
        {hold_p, hold_s, rst_p, rst_s}, 0);
  endtask

  task automatic read_one(input string extra);
    logic [2:0] ch;
    logic [15:0] d;
    logic dv, fin, pe;
    logic [15:0] e;
    string rq;
    @(negedge clk);
    rd_ni = 1'b0;
    @(negedge clk);
    if (m_mode < 3'd6) begin
      ch = m_mode; d = smp[m_mode*DW +: DW]; dv = vld[m_mode];
    end else if (m_mode == 3'd6) begin
      ch = 3'(m_ptr); d = smp[m_ptr*DW +: DW]; dv = vld[m_ptr];
    end else begin
      ch = fch; d = fdat; dv = ~fempty;
    end
    e = exp_word(m_mode, m_add, byte_w, m_step, ch, d, dv);
    rq = {req_of(m_mode, m_add, byte_w), extra};
    chk(dout_p == e, {rq, " pin-cfg"}, dout_p, e);
    chk(dout_s == e, {rq, " write-cfg"}, dout_s, e);
    fin = (m_step == n_steps(m_mode, m_add, byte_w) - 1);
    rd_ni = 1'b1;
    #1;
    pe = fin && m_mode == 3'd7 && !fempty;
    chk(pop_p == pe && pop_s == pe, "R7 pop", {pop_p, pop_s}, {pe, pe});
    if (fin) begin
      m_step = 0;
      if (m_mode == 3'd6) m_ptr = (m_ptr + 1) % NCH;
    end else m_step++;
    @(negedge clk);
  endtask

  task automatic new_data;
    for (int i = 0; i < NCH; i++) smp[i*DW +: DW] = 16'($urandom);
    vld    = 6'($urandom);
    fdat   = 16'($urandom);
    fch    = 3'($urandom % NCH);
    fempty = ($urandom % 4) == 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    new_data();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(hold_p == 0 && hold_s == 0 && !rst_p && !rst_s, "R1 commands idle", {hold_p, hold_s}, 0);
    chk(!pop_p && !pop_s, "R1 no pop", {pop_p, pop_s}, 0);
    chk(dout_s == smp[15:0], "R1 write-cfg default mode 0", dout_s, smp[15:0]);

    // R2 direct, tag ignored
    for (int c = 0; c < NCH; c++) begin
      set_cfg(3'(c), 1'b1);
      read_one(" direct tag-ignored");
    end
    // R3 byte split
    byte_w = 1'b1;
    set_cfg(3'd4, 1'b0);
    read_one(""); read_one("");
    byte_w = 1'b0;

    // R4 cycle wrap after reset command
    set_cfg(3'd6, 1'b0);
    read_one(" pre-reset");
    cmd(1'b1, 3'b000);
    for (int i = 0; i < NCH + 2; i++) read_one(" cycle order");

    // R5 / R6 tagged
    set_cfg(3'd6, 1'b1);
    read_one(""); read_one("");
    byte_w = 1'b1;
    read_one(""); read_one(""); read_one("");

    // R11 mode change mid-sequence
    read_one(" partial");
    set_cfg(3'd7, 1'b1);
    read_one(" R11 after mode change");
    read_one(""); read_one("");

    // R7 empty FIFO gives no pop
    byte_w = 1'b0;
    fempty = 1'b1;
    set_cfg(3'd7, 1'b0);
    read_one(" empty");
    fempty = 1'b0;
    read_one(" nonempty");

    // R8 command write keeps configuration, R9 holds
    cmd(1'b0, 3'b101);
    read_one(" R8 cfg kept");
    cmd(1'b0, 3'b010);

    for (int it = 0; it < 400; it++) begin
      int a;
      a = int'($urandom % 10);
      if (a < 2) begin
        logic [2:0] md;
        logic ad;
        md = 3'($urandom);
        ad = 1'($urandom);
        if (m_step != 0 && md == m_mode) ad = m_add;
        set_cfg(md, ad);
      end else if (a == 2) begin
        cmd(($urandom % 4) == 0, 3'($urandom));
      end else if (a == 3) begin
        if (m_step == 0) byte_w = 1'($urandom);
        new_data();
      end else begin
        read_one(" random");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule